// File: doc/BRIEF.md
# Interrupt Enable and Pending Latch Controller

This block gathers five event sources into one interrupt request for a host processor. The sources are an external pin, two timers, an asynchronous serial port and a synchronous serial port. Each source has an enable bit and a sticky pending bit. A rising edge on an enabled source sets its pending bit, but only while the global gate input is high. The gate is the enable that the downstream interrupt controller gives to this block. The request output stays high while any pending bit is set.

The host reaches the block through a single 16-bit register location. The meaning of that location depends on the direction of the access and on the byte lane.

- A write to the low byte (the odd byte address) loads the enable mask.
- Ones written to the high byte (the even byte address) clear the matching pending bits.
- A full-word write does both in the same access.
- Any read returns the pending bits instead of the mask.

Top module: `irqc_latch_ctrl`

## Requirements
- R1: After reset, the enable mask and every pending bit are zero, `irq_o` is low, and a word read returns 0.
- R2: Source and bit positions match in the mask, the clear field and the pending bits: bit 0 external, bit 1 timer 1, bit 2 timer 2, bit 3 asynchronous serial, bit 4 synchronous serial.
- R3: A word write (`bus_word`=1) loads the mask from `bus_wdata[4:0]` and, in the same cycle, clears every pending bit whose clear bit `bus_wdata[12:8]` is 1.
- R4: A byte write to the even address (`bus_word`=0, `bus_addr0`=0) treats `bus_wdata[4:0]` as a clear mask and leaves the enable mask unchanged.
- R5: A byte write to the odd address (`bus_word`=0, `bus_addr0`=1) loads the mask from `bus_wdata[4:0]` and leaves the pending bits unchanged.
- R6: When `bus_sel`=1 and `bus_wr`=0, `rdata` returns the pending bits in bits [4:0] for a word read or an odd-address byte read, and returns 0 for an even-address byte read. `rdata` is 0 when no read is in progress.
- R7: A 0-to-1 transition on an enabled source with `gate_i`=1 sets its pending bit at the next clock edge. A source held high sets its bit only once.
- R8: A source whose enable bit is 0, or any source while `gate_i`=0, never sets a pending bit.
- R9: `irq_o` is high exactly when some pending bit is set, and stays high until software clears the bit.
- R10: When a set and a clear reach the same pending bit in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 5 | Source event lines, bit order as in R2 |
| gate_i | input | 1 | Global gate; events latch only while high |
| bus_sel | input | 1 | Host access to the register this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_word | input | 1 | 1 word access, 0 byte access |
| bus_addr0 | input | 1 | Byte address bit 0 (0 even/high lane, 1 odd/low lane) |
| bus_wdata | input | 16 | Write data; byte writes use bits [7:0] |
| bus_rdata | output | 16 | Read data (pending bits) |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The main pattern sweeps all 32 enable masks against all 32 source-edge patterns. In each case the pending value must equal the AND of mask and pattern, which shows that every source is gated only by its own bit. Separate patterns cover the following:

- A gated-off run shows that the global gate overrides the enables.
- A source held high shows that capture is on edges and not on levels.
- Byte writes to each lane, followed by fresh events, show which lane reaches the mask and which reaches the clear logic.
- A clear that coincides with an event shows that the set takes priority.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned SRC_N    = 5;
   localparam int unsigned BUS_W    = 16;
   localparam int unsigned CLR_BASE = 8;

   typedef enum logic {
      ACC_BYTE = 1'b0,
      ACC_WORD = 1'b1
   } acc_size_e;

   typedef enum logic {
      LANE_HIGH = 1'b0,
      LANE_LOW  = 1'b1
   } byte_lane_e;
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src,
   output logic [N-1:0] rise
);
   logic [N-1:0] prev_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q[i] <= 1'b0;
         else        prev_q[i] <= src[i];
      end
      assign rise[i] = src[i] & ~prev_q[i];
   end

   // R7: an edge can only be reported when the line was low one cycle earlier
   p_rise_after_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((rise & $past(src)) == '0));
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic [N-1:0] en,
   input  logic         gate,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);
   logic [N-1:0] set_v;
   logic [N-1:0] pend_q;

   assign set_v = ev & en & {N{gate}};

   for (genvar i = 0; i < N; i++) begin : g_latch
      always_ff @(posedge clk) begin
         if (!rst_n)        pend_q[i] <= 1'b0;
         else if (set_v[i]) pend_q[i] <= 1'b1;
         else if (clr[i])   pend_q[i] <= 1'b0;
      end
   end

   assign pend = pend_q;

   p_set_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((pend_q & ~$past(pend_q)) & ~$past(ev & en & {N{gate}})) == '0));

   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_v) |=> ((pend_q & $past(set_v)) == $past(set_v)));

   p_clear_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr & ~set_v)) |=> ((pend_q & $past(clr & ~set_v)) == '0));
endmodule

// File: rtl/irqc_host_if.sv
module irqc_host_if
   import irqc_pkg::*;
#(
   parameter int unsigned N    = SRC_N,
   parameter int unsigned DW   = BUS_W,
   parameter int unsigned CLRB = CLR_BASE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          wr,
   input  logic          word,
   input  logic          addr0,
   input  logic [DW-1:0] wdata,
   input  logic [N-1:0]  pend,
   output logic [N-1:0]  mask,
   output logic [N-1:0]  clr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned PADW = DW - N;

   acc_size_e    size;
   byte_lane_e   lane;
   logic         wstb;
   logic         rstb;
   logic         mask_ld;
   logic [N-1:0] mask_q;

   assign size = acc_size_e'(word);
   assign lane = byte_lane_e'(addr0);
   assign wstb = sel & wr;
   assign rstb = sel & ~wr;

   always_comb begin
      mask_ld = 1'b0;
      clr     = '0;
      if (wstb) begin
         if (size == ACC_WORD) begin
            mask_ld = 1'b1;
            clr     = wdata[CLRB +: N];
         end else if (lane == LANE_LOW) begin
            mask_ld = 1'b1;
         end else begin
            clr     = wdata[N-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_ld) mask_q <= wdata[N-1:0];
   end

   assign mask = mask_q;

   always_comb begin
      rdata = '0;
      if (rstb && (size == ACC_WORD || lane == LANE_LOW))
         rdata = {{PADW{1'b0}}, pend};
   end

   p_even_lane_keeps_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && !word && !addr0) |=> $stable(mask_q));

   p_odd_lane_no_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && !word && addr0) |-> (clr == '0));
endmodule

// File: rtl/irqc_latch_ctrl.sv
module irqc_latch_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned N    = SRC_N,
   parameter int unsigned DW   = BUS_W,
   parameter int unsigned CLRB = CLR_BASE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  src_i,
   input  logic          gate_i,
   input  logic          bus_sel,
   input  logic          bus_wr,
   input  logic          bus_word,
   input  logic          bus_addr0,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          irq_o
);
   initial begin
      assert (N >= 1 && N <= 8) else $error("source count must fit a byte lane");
      assert (CLRB >= 8 && CLRB + N <= DW) else $error("clear field out of range");
   end

   logic [N-1:0] rise;
   logic [N-1:0] mask;
   logic [N-1:0] clr;
   logic [N-1:0] pend;

   irqc_edge #(.N(N)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .src  (src_i),
      .rise (rise)
   );

   irqc_host_if #(.N(N), .DW(DW), .CLRB(CLRB)) u_host (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (bus_sel),
      .wr   (bus_wr),
      .word (bus_word),
      .addr0(bus_addr0),
      .wdata(bus_wdata),
      .pend (pend),
      .mask (mask),
      .clr  (clr),
      .rdata(bus_rdata)
   );

   irqc_pend #(.N(N)) u_pend (
      .clk (clk),
      .rst_n(rst_n),
      .ev  (rise),
      .en  (mask),
      .gate(gate_i),
      .clr (clr),
      .pend(pend)
   );

   assign irq_o = |pend;

   p_irq_drops_on_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(|clr));
endmodule

// File: tb/irqc_latch_ctrl_tb.sv
module irqc_latch_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  src_i = '0;
   logic        gate_i = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_word = 1'b0;
   logic        bus_addr0 = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   irqc_latch_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .gate_i(gate_i),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
      .bus_addr0(bus_addr0), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_acc(input logic word, input logic a0, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_word = word; bus_addr0 = a0; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_acc(input logic word, input logic a0, output logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_word = word; bus_addr0 = a0;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic pulse(input logic [4:0] p);
      @(negedge clk);
      src_i = p;
      @(negedge clk);
      src_i = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [15:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd_acc(1'b1, 1'b0, r);
      chk("R1 reset pending", r, 16'h0);
      chk("R1 reset irq", {15'b0, irq_o}, 16'h0);
      pulse(5'h1F);
      gate_i = 1'b1;
      rd_acc(1'b1, 1'b0, r);
      chk("R1 reset mask zero", r, 16'h0);

      // R2/R3/R7/R9 sweep over masks and edge patterns
      for (int m = 0; m < 32; m++) begin
         for (int p = 0; p < 32; p++) begin
            wr_acc(1'b1, 1'b0, 16'h1F00 | 16'(m));
            rd_acc(1'b1, 1'b0, r);
            chk("R3 word clear", r, 16'h0);
            pulse(5'(p));
            rd_acc(1'b1, 1'b0, r);
            chk("R2 R7 pending=mask&edge", r, 16'(m & p));
            chk("R9 irq is any pending", {15'b0, irq_o}, {15'b0, |(5'(m & p))});
         end
      end

      // R8 gate low blocks everything
      wr_acc(1'b1, 1'b0, 16'h1F1F);
      gate_i = 1'b0;
      pulse(5'h1F);
      rd_acc(1'b1, 1'b0, r);
      chk("R8 gate low", r, 16'h0);
      gate_i = 1'b1;

      // R7 held source sets only once
      @(negedge clk); src_i = 5'h04;
      @(negedge clk);
      wr_acc(1'b1, 1'b0, 16'h1F1F);
      repeat (4) @(negedge clk);
      rd_acc(1'b1, 1'b0, r);
      chk("R7 held level no reset", r, 16'h0);
      src_i = '0;

      // R9 irq holds until cleared
      pulse(5'h10);
      repeat (10) @(negedge clk);
      chk("R9 irq held", {15'b0, irq_o}, 16'h1);
      wr_acc(1'b1, 1'b0, 16'h101F);
      chk("R9 irq dropped", {15'b0, irq_o}, 16'h0);

      // R4 even byte is clear-only
      pulse(5'h1F);
      wr_acc(1'b0, 1'b0, 16'h0005);
      rd_acc(1'b1, 1'b0, r);
      chk("R4 even byte clears", r, 16'h001A);
      wr_acc(1'b0, 1'b0, 16'h001F);
      pulse(5'h1F);
      rd_acc(1'b1, 1'b0, r);
      chk("R4 mask unchanged", r, 16'h001F);

      // R6 lane reads
      rd_acc(1'b0, 1'b0, r);
      chk("R6 even byte read", r, 16'h0);
      rd_acc(1'b0, 1'b1, r);
      chk("R6 odd byte read", r, 16'h001F);
      #1 chk("R6 idle rdata", bus_rdata, 16'h0);

      // R5 odd byte is mask-only
      wr_acc(1'b0, 1'b1, 16'h1F03);
      rd_acc(1'b1, 1'b0, r);
      chk("R5 pending unchanged", r, 16'h001F);
      wr_acc(1'b0, 1'b0, 16'h001F);
      pulse(5'h1F);
      rd_acc(1'b1, 1'b0, r);
      chk("R5 new mask", r, 16'h0003);

      // R10 set wins over same-cycle clear
      wr_acc(1'b1, 1'b0, 16'h1F1F);
      @(negedge clk);
      src_i = 5'h04;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_word = 1'b1; bus_wdata = 16'h1F1F;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; src_i = '0;
      rd_acc(1'b1, 1'b0, r);
      chk("R10 set wins", r, 16'h0004);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule